// File: doc/BRIEF.md
# Low-Side Output Gate Command Selector

This block produces the final on/off gate command for each of sixteen low-side output switches. Every channel has a software on/off bit. A per-channel enable can hand that channel to a single shared modulation pin; a per-channel select then decides whether the pin gates the software bit (AND) or can only add on-time to it (OR). Eight of the channels also have a private modulation pin. That pin is merged with the software bit by OR while the channel is not using the shared pin, and it is ignored once the channel has been handed to the shared pin.

All modulation pins are asynchronous to the block clock. They pass through a two-flop synchronizer before any use. The combined command is registered. A per-channel protection mask from the fault logic then clears the registered command without waiting for a clock edge. The register contents arrive as plain input vectors from the command decoder.

Top module: `outgate_select`

## Requirements
- R1: While `rstN` is low every bit of `gateOut` is 0, whatever the other inputs are.
- R2: For a channel with `pwmEn` bit 0 and no private pin, `gateOut` follows its `onOff` bit one clock edge later. `sharedPwm` and `andOrSel` have no effect on it.
- R3: For a channel with `pwmEn` bit 1 and `andOrSel` bit 0, the command is `onOff` AND the synchronized `sharedPwm`.
- R4: For a channel with `pwmEn` bit 1 and `andOrSel` bit 1, the command is `onOff` OR the synchronized `sharedPwm`.
- R5: For a channel with `pwmEn` bit 1, its private pin has no effect.
- R6: For a channel that has a private pin and `pwmEn` bit 0, the command is `onOff` OR the synchronized private pin. `sharedPwm` has no effect on it.
- R7: Private pin bits `dedPwm[0]` to `dedPwm[7]` drive outputs 0, 1, 6, 7, 8, 9, 14 and 15, in that order. The other outputs have no private pin.
- R8: A change on a modulation pin reaches `gateOut` on the third rising clock edge after it. A change on `onOff`, `pwmEn` or `andOrSel` reaches `gateOut` on the first rising edge.
- R9: A `faultMask` bit of 1 forces the matching `gateOut` bit to 0 in the same cycle, with no clock edge needed. Clearing the mask bit restores the command at once.
- R10: The `andOrSel` bits act per channel, so AND and OR channels can be mixed in one configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| onOff | input | 16 | Software on/off bit per output |
| pwmEn | input | 16 | 1 hands the channel to the shared pin |
| andOrSel | input | 16 | Per channel: 0 = AND, 1 = OR with the shared pin |
| sharedPwm | input | 1 | Shared modulation pin, asynchronous |
| dedPwm | input | 8 | Private modulation pins for outputs 0,1,6,7,8,9,14,15 |
| faultMask | input | 16 | Protection shutdown per output, 1 = force off |
| gateOut | output | 16 | Final gate command per output |

## Verification
The bench reads the block only through `gateOut`, so each fault it targets has to show up there. A wrong pin-to-channel mapping lights the wrong output bit as soon as the synchronizer has settled, three edges after the pin moves. A swapped AND/OR sense, or a private pin that is not blocked, shows as a wrong level on the first vector that holds the shared pin opposite to the software bit. A synchronizer with the wrong depth moves the output one edge early or late. A mask that is held in a register instead of applied directly leaves the output high for part of a clock period.

// File: rtl/outgate_pkg.sv
package outgate_pkg;

  localparam int OUT_COUNT = 16;

  typedef struct packed {
    logic [OUT_COUNT-1:0] selShared;
    logic [OUT_COUNT-1:0] orMode;
    logic [OUT_COUNT-1:0] dedEnable;
  } gateStrobe_t;

  function automatic int dedCount(input logic [OUT_COUNT-1:0] pinMap);
    int n = 0;
    for (int i = 0; i < OUT_COUNT; i++) n += int'(pinMap[i]);
    return n;
  endfunction

  function automatic int dedIndex(input logic [OUT_COUNT-1:0] pinMap, input int ch);
    int n = 0;
    for (int i = 0; i < OUT_COUNT; i++)
      if (i < ch) n += int'(pinMap[i]);
    return n;
  endfunction

endpackage

// File: rtl/pwm_pin_sync.sv
module pwm_pin_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinAsync,
  output logic [WIDTH-1:0] pinSync
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= pinAsync;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign pinSync = chain[STAGES-1];

endmodule

// File: rtl/gate_ctl.sv
module gate_ctl
  import outgate_pkg::*;
#(
  parameter logic [OUT_COUNT-1:0] DED_MAP = 16'hC3C3
) (
  input  logic [OUT_COUNT-1:0] pwmEn,
  input  logic [OUT_COUNT-1:0] andOrSel,
  output gateStrobe_t          ctl
);

  // The shared pin takes the channel when enabled; the private pin only otherwise.
  always_comb begin
    ctl.selShared = pwmEn;
    ctl.orMode    = andOrSel & pwmEn;
    ctl.dedEnable = ~pwmEn & DED_MAP;
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import outgate_pkg::*;
#(
  parameter logic [OUT_COUNT-1:0] DED_MAP = 16'hC3C3,
  parameter int NUM_DED = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobe_t          ctl,
  input  logic [OUT_COUNT-1:0] onOff,
  input  logic                 sharedSync,
  input  logic [NUM_DED-1:0]   dedSync,
  input  logic [OUT_COUNT-1:0] faultMask,
  output logic [OUT_COUNT-1:0] gateOut
);

  logic [OUT_COUNT-1:0] dedTerm;
  logic [OUT_COUNT-1:0] nextGate;
  logic [OUT_COUNT-1:0] gateQ;

  for (genvar ch = 0; ch < OUT_COUNT; ch++) begin : g_chan
    if (DED_MAP[ch]) begin : g_ded
      localparam int K = dedIndex(DED_MAP, ch);
      assign dedTerm[ch] = ctl.dedEnable[ch] & dedSync[K];
    end else begin : g_noded
      assign dedTerm[ch] = ctl.dedEnable[ch] & 1'b0;
    end

    assign nextGate[ch] = ctl.selShared[ch]
                          ? (ctl.orMode[ch] ? (onOff[ch] | sharedSync)
                                            : (onOff[ch] & sharedSync))
                          : (onOff[ch] | dedTerm[ch]);

    assert_and_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.selShared[ch] && !ctl.orMode[ch] && !onOff[ch]) |=> !gateQ[ch]);

    assert_or_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.selShared[ch] && ctl.orMode[ch] && onOff[ch]) |=> gateQ[ch]);

    if (!DED_MAP[ch]) begin : g_follow
      assert_follow_onoff_R2: assert property (@(posedge clk) disable iff (!rstN)
        !ctl.selShared[ch] |=> (gateQ[ch] == $past(onOff[ch])));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else       gateQ <= nextGate;
  end

  // Protection acts without a clock edge.
  assign gateOut = gateQ & ~faultMask;

  assert_reset_off_R1: assert property (@(posedge clk) !rstN |=> (gateQ == '0));

endmodule

// File: rtl/outgate_select.sv
module outgate_select
  import outgate_pkg::*;
#(
  parameter logic [OUT_COUNT-1:0] DED_MAP = 16'hC3C3,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_DED = dedCount(DED_MAP)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OUT_COUNT-1:0] onOff,
  input  logic [OUT_COUNT-1:0] pwmEn,
  input  logic [OUT_COUNT-1:0] andOrSel,
  input  logic                 sharedPwm,
  input  logic [NUM_DED-1:0]   dedPwm,
  input  logic [OUT_COUNT-1:0] faultMask,
  output logic [OUT_COUNT-1:0] gateOut
);

  gateStrobe_t        ctl;
  logic [NUM_DED:0]   pinSync;

  pwm_pin_sync #(.WIDTH(NUM_DED + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync ({sharedPwm, dedPwm}),
    .pinSync  (pinSync)
  );

  gate_ctl #(.DED_MAP(DED_MAP)) u_ctl (
    .pwmEn    (pwmEn),
    .andOrSel (andOrSel),
    .ctl      (ctl)
  );

  gate_datapath #(.DED_MAP(DED_MAP), .NUM_DED(NUM_DED)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .onOff      (onOff),
    .sharedSync (pinSync[NUM_DED]),
    .dedSync    (pinSync[NUM_DED-1:0]),
    .faultMask  (faultMask),
    .gateOut    (gateOut)
  );

endmodule

// File: tb/outgate_select_test.sv
`timescale 1ns/1ps
module outgate_select_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] onOff = '0, pwmEn = '0, andOrSel = '0, faultMask = '0;
  logic        sharedPwm = 1'b0;
  logic [7:0]  dedPwm = '0;
  logic [15:0] gateOut;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  outgate_select uut (
    .clk(clk), .rstN(rstN), .onOff(onOff), .pwmEn(pwmEn), .andOrSel(andOrSel),
    .sharedPwm(sharedPwm), .dedPwm(dedPwm), .faultMask(faultMask), .gateOut(gateOut)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [15:0] on, en, ao;
    logic        sh;
    logic [7:0]  ded;
    logic [15:0] mask, exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 16'hA5A5, 16'h0000, 16'h0000, 1'b0, 8'h00, 16'h0000, 16'hA5A5},
    '{"R2 ", 16'hA5A5, 16'h0000, 16'hFFFF, 1'b1, 8'h00, 16'h0000, 16'hA5A5},
    '{"R6 ", 16'h0000, 16'h0000, 16'h0000, 1'b1, 8'hFF, 16'h0000, 16'hC3C3},
    '{"R6 ", 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'h24, 16'h0000, 16'h0240},
    '{"R6 ", 16'h0100, 16'h0000, 16'h0000, 1'b0, 8'h81, 16'h0000, 16'h8101},
    '{"R3 ", 16'h00FF, 16'hFFFF, 16'h0000, 1'b0, 8'hFF, 16'h0000, 16'h0000},
    '{"R3 ", 16'h00FF, 16'hFFFF, 16'h0000, 1'b1, 8'h00, 16'h0000, 16'h00FF},
    '{"R4 ", 16'h00FF, 16'hFFFF, 16'hFFFF, 1'b0, 8'h00, 16'h0000, 16'h00FF},
    '{"R4 ", 16'h00FF, 16'hFFFF, 16'hFFFF, 1'b1, 8'h00, 16'h0000, 16'hFFFF},
    '{"R10", 16'h1234, 16'hFF00, 16'hF000, 1'b1, 8'h00, 16'h0000, 16'hF234},
    '{"R10", 16'h1234, 16'hFF00, 16'hF000, 1'b0, 8'h00, 16'h0000, 16'h1034},
    '{"R5 ", 16'h0000, 16'hC3C3, 16'h0000, 1'b1, 8'hFF, 16'h0000, 16'h0000},
    '{"R5 ", 16'h0000, 16'hC3C3, 16'h0000, 1'b0, 8'hFF, 16'h0000, 16'h0000},
    '{"R9 ", 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 8'h00, 16'h0F0F, 16'hF0F0},
    '{"R9 ", 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'hFF, 16'h0003, 16'hC3C0}
  };

  localparam int DED_CH [8] = '{0, 1, 6, 7, 8, 9, 14, 15};

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset holds every output off even with all inputs asking for on
    onOff = 16'hFFFF; dedPwm = 8'hFF; sharedPwm = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset output", gateOut, 16'h0000);
    @(negedge clk);
    check("R1 reset output held", gateOut, 16'h0000);
    onOff = '0; dedPwm = '0; sharedPwm = 1'b0;
    rstN = 1'b1;
    settle();
    check("R1 after release", gateOut, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      onOff = VECS[i].on; pwmEn = VECS[i].en; andOrSel = VECS[i].ao;
      sharedPwm = VECS[i].sh; dedPwm = VECS[i].ded; faultMask = VECS[i].mask;
      settle();
      check($sformatf("%s vector %0d", VECS[i].tag, i), gateOut, VECS[i].exp);
    end

    // R7: walk one private pin at a time
    onOff = '0; pwmEn = '0; andOrSel = '0; sharedPwm = 1'b0; faultMask = '0;
    for (int k = 0; k < 8; k++) begin
      dedPwm = 8'(1 << k);
      settle();
      check($sformatf("R7 private pin %0d", k), gateOut, 16'(1 << DED_CH[k]));
    end

    // R8: pin latency is three edges, register latency is one
    dedPwm = '0;
    settle();
    dedPwm = 8'h01;
    @(posedge clk); @(negedge clk);
    check("R8 pin edge 1", gateOut, 16'h0000);
    @(posedge clk); @(negedge clk);
    check("R8 pin edge 2", gateOut, 16'h0000);
    @(posedge clk); @(negedge clk);
    check("R8 pin edge 3", gateOut, 16'h0001);
    onOff = 16'h0010;
    @(posedge clk); @(negedge clk);
    check("R8 register edge 1", gateOut, 16'h0011);

    // R9: mask acts without a clock edge and releases at once
    faultMask = 16'h0011;
    #1;
    check("R9 mask immediate", gateOut, 16'h0000);
    faultMask = '0;
    #0.5;
    check("R9 mask release", gateOut, 16'h0011);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule